// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block is the combinational execute stage of a 64-bit branch unit. It takes one decoded branch operation and produces three valid/data pairs: the next instruction address, the value to write to the link register, and the updated loop counter. The operation kind picks the form: an unconditional jump with a long immediate, a conditional jump with a short immediate, or a conditional jump to an address held in a special register.

A five-bit control field steers every conditional decision. It can skip the condition-register test or compare the selected condition bit against either polarity. It can also decrement the counter and test it for zero, and it decides which outputs are flagged valid. The 64-bit special-register input is both the loop counter and, for the register form, the branch target. An opaque operation-context word rides through unchanged. Nothing is registered, so results follow the inputs in the same cycle.

Top module: `br_resolve`

## Requirements
- R1: `op_kind` encodes 0 = unconditional, 1 = conditional-immediate, 2 = conditional-to-register. The unconditional form always sets `nia_vld` and never sets `ctr_vld`.
- R2: In the unconditional form the 24-bit `imm_long` is sign-extended and shifted left by two. When `abs_tgt` is 1 the target is that value. Otherwise it is `cur_addr` plus that value, modulo 2^64.
- R3: In the conditional-immediate form the 14-bit `imm_short` is sign-extended and shifted left by two. It forms the target by the same absolute/relative rule as R2.
- R4: In the conditional-to-register form a taken branch targets `spr_in` exactly.
- R5: `cr_field` holds the selected 4-bit condition field, numbered from its MSB. `bit_sel` value k picks `cr_field[3-k]` as the condition bit.
- R6: The condition test passes when `ctl_mode[4]` is 1, or when the condition bit equals `ctl_mode[3]`.
- R7: When `ctl_mode[2]` is 0 in a conditional form, `ctr_vld` is 1 and `ctr_data` is `spr_in` minus one, modulo 2^64. When `ctl_mode[2]` is 1, `ctr_vld` is 0.
- R8: The counter test passes when `ctl_mode[2]` is 1, or when (`spr_in` is nonzero) XOR `ctl_mode[1]` is 1. The test uses the counter value before the decrement.
- R9: In both conditional forms `nia_vld` equals the condition test AND the counter test. `nia_data` has meaning only when `nia_vld` is 1.
- R10: For the three defined forms `lnk_vld` equals `link_en`. `lnk_data` is `cur_addr` plus 4, modulo 2^64.
- R11: `ctx_out` always equals `ctx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_kind | input | 2 | Branch form (R1 encoding) |
| cur_addr | input | 64 | Address of the branch instruction |
| imm_long | input | 24 | Long word displacement |
| imm_short | input | 14 | Short word displacement |
| ctl_mode | input | 5 | Branch control field |
| bit_sel | input | 2 | Bit index inside the condition field |
| abs_tgt | input | 1 | Use immediate as absolute target |
| link_en | input | 1 | Request link write |
| cr_field | input | 4 | Selected condition-register field |
| spr_in | input | 64 | Counter value and register target |
| ctx_in | input | 8 | Operation context |
| nia_vld | output | 1 | Branch taken |
| nia_data | output | 64 | Next instruction address |
| lnk_vld | output | 1 | Link write valid |
| lnk_data | output | 64 | Return address |
| ctr_vld | output | 1 | Counter write valid |
| ctr_data | output | 64 | Decremented counter |
| ctx_out | output | 8 | Context passed through |

## Verification
The counter decrement and the branch decision can occur in the same cycle. The zero test must see the old counter value, while the counter output carries the new one. Vectors with counter values of 0 and 1 under both zero-test polarities provoke this. A model that computes the decision from the pre-decrement value judges them, and checks `ctr_data` separately. In the register form the special-register input is both the target and the counter, so taken branches with a decrement are checked for a target of the undecremented value.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    BR_UNCOND   = 2'd0,
    BR_COND_IMM = 2'd1,
    BR_COND_REG = 2'd2
  } br_op_e;

  // control-field bit positions
  localparam int CTL_SKIP_CR  = 4;
  localparam int CTL_CR_POL   = 3;
  localparam int CTL_NO_CNT   = 2;
  localparam int CTL_ZERO_POL = 1;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval #(
  parameter int XLEN  = 64,
  parameter int CRF_W = 4,
  localparam int SEL_W = $clog2(CRF_W)
) (
  input  logic [4:0]       ctl,
  input  logic [SEL_W-1:0] sel,
  input  logic [CRF_W-1:0] crf,
  input  logic [XLEN-1:0]  cnt,
  output logic             cond_ok,
  output logic             cnt_ok
);
  import br_pkg::*;

  logic cbit;
  logic cnt_nz;

  always_comb begin
    cbit    = crf[SEL_W'(CRF_W-1) - sel];
    cond_ok = ctl[CTL_SKIP_CR] | (cbit == ctl[CTL_CR_POL]);
    cnt_nz  = |cnt;
    cnt_ok  = ctl[CTL_NO_CNT] | (cnt_nz ^ ctl[CTL_ZERO_POL]);
  end
endmodule

// File: rtl/br_ctr_unit.sv
module br_ctr_unit #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] cnt_in,
  output logic [XLEN-1:0] cnt_next
);
  always_comb cnt_next = cnt_in - XLEN'(1);
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
  parameter int XLEN = 64,
  parameter int LI_W = 24,
  parameter int BD_W = 14
) (
  input  logic            use_long,
  input  logic            abs_sel,
  input  logic [XLEN-1:0] base,
  input  logic [LI_W-1:0] li,
  input  logic [BD_W-1:0] bd,
  output logic [XLEN-1:0] tgt
);
  localparam int LI_PAD = XLEN - LI_W - 2;
  localparam int BD_PAD = XLEN - BD_W - 2;

  logic [XLEN-1:0] li_off;
  logic [XLEN-1:0] bd_off;
  logic [XLEN-1:0] off;

  always_comb begin
    li_off = {{LI_PAD{li[LI_W-1]}}, li, 2'b00};
    bd_off = {{BD_PAD{bd[BD_W-1]}}, bd, 2'b00};
    off    = use_long ? li_off : bd_off;
    tgt    = abs_sel ? off : (base + off);
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve #(
  parameter int XLEN  = 64,
  parameter int LI_W  = 24,
  parameter int BD_W  = 14,
  parameter int CRF_W = 4,
  parameter int CTX_W = 8,
  localparam int SEL_W = $clog2(CRF_W)
) (
  input  logic [1:0]       op_kind,
  input  logic [XLEN-1:0]  cur_addr,
  input  logic [LI_W-1:0]  imm_long,
  input  logic [BD_W-1:0]  imm_short,
  input  logic [4:0]       ctl_mode,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             abs_tgt,
  input  logic             link_en,
  input  logic [CRF_W-1:0] cr_field,
  input  logic [XLEN-1:0]  spr_in,
  input  logic [CTX_W-1:0] ctx_in,
  output logic             nia_vld,
  output logic [XLEN-1:0]  nia_data,
  output logic             lnk_vld,
  output logic [XLEN-1:0]  lnk_data,
  output logic             ctr_vld,
  output logic [XLEN-1:0]  ctr_data,
  output logic [CTX_W-1:0] ctx_out
);
  import br_pkg::*;

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  br_op_e          op;
  logic            cond_ok;
  logic            cnt_ok;
  logic            take_cond;
  logic            dec_req;
  logic [XLEN-1:0] imm_tgt;
  logic [XLEN-1:0] cnt_next;
  logic            unused_ctl0;

  assign op          = br_op_e'(op_kind);
  assign unused_ctl0 = ctl_mode[0];

  br_cond_eval #(.XLEN(XLEN), .CRF_W(CRF_W)) i_cond (
    .ctl     (ctl_mode),
    .sel     (bit_sel),
    .crf     (cr_field),
    .cnt     (spr_in),
    .cond_ok (cond_ok),
    .cnt_ok  (cnt_ok)
  );

  br_ctr_unit #(.XLEN(XLEN)) i_ctr (
    .cnt_in   (spr_in),
    .cnt_next (cnt_next)
  );

  br_target_gen #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W)) i_tgt (
    .use_long (op == BR_UNCOND),
    .abs_sel  (abs_tgt),
    .base     (cur_addr),
    .li       (imm_long),
    .bd       (imm_short),
    .tgt      (imm_tgt)
  );

  assign take_cond = cond_ok & cnt_ok;
  assign dec_req   = ~ctl_mode[CTL_NO_CNT];

  always_comb begin
    nia_vld  = 1'b0;
    nia_data = imm_tgt;
    ctr_vld  = 1'b0;
    lnk_vld  = 1'b0;
    unique case (op)
      BR_UNCOND: begin
        nia_vld = 1'b1;
        lnk_vld = link_en;
      end
      BR_COND_IMM: begin
        nia_vld = take_cond;
        ctr_vld = dec_req;
        lnk_vld = link_en;
      end
      BR_COND_REG: begin
        nia_vld  = take_cond;
        nia_data = spr_in;
        ctr_vld  = dec_req;
        lnk_vld  = link_en;
      end
      default: ;
    endcase
  end

  assign lnk_data = cur_addr + INSN_BYTES;
  assign ctr_data = cnt_next;
  assign ctx_out  = ctx_in;
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int XLEN  = 64,
  parameter int CTX_W = 8
) (
  input logic [1:0]       op_kind,
  input logic [XLEN-1:0]  cur_addr,
  input logic [4:0]       ctl_mode,
  input logic             link_en,
  input logic [XLEN-1:0]  spr_in,
  input logic [CTX_W-1:0] ctx_in,
  input logic             nia_vld,
  input logic [XLEN-1:0]  nia_data,
  input logic             lnk_vld,
  input logic [XLEN-1:0]  lnk_data,
  input logic             ctr_vld,
  input logic [XLEN-1:0]  ctr_data,
  input logic [CTX_W-1:0] ctx_out
);
  logic is_cond;
  assign is_cond = (op_kind == 2'd1) || (op_kind == 2'd2);

  always_comb begin
    if (!$isunknown(op_kind) && !$isunknown(ctl_mode)) begin
      if (op_kind == 2'd0) begin
        assert_uncond_taken_R1: assert (nia_vld && !ctr_vld)
          else $error("unconditional form not taken or writes counter");
      end
      if (is_cond) begin
        assert_ctr_write_R7: assert (ctr_vld == !ctl_mode[2])
          else $error("counter valid flag disagrees with control");
        if (ctr_vld) begin
          assert_ctr_dec_R7: assert (ctr_data + XLEN'(1) == spr_in)
            else $error("counter output is not input minus one");
        end
        if (ctl_mode[4] && ctl_mode[2]) begin
          assert_always_taken_R9: assert (nia_vld)
            else $error("unconditional control setting not taken");
        end
        if (op_kind == 2'd2 && nia_vld) begin
          assert_reg_target_R4: assert (nia_data == spr_in)
            else $error("register form target mismatch");
        end
      end
      if (op_kind != 2'd3) begin
        assert_link_R10: assert (lnk_vld == link_en &&
                                 (lnk_data - cur_addr) == XLEN'(4))
          else $error("link output mismatch");
      end
    end
    if (!$isunknown(ctx_in)) begin
      assert_ctx_pass_R11: assert (ctx_out == ctx_in)
        else $error("context not passed through");
    end
  end
endmodule

bind br_resolve br_resolve_chk #(.XLEN(XLEN), .CTX_W(CTX_W)) i_chk (.*);

// File: tb/test_br_resolve.sv
module test_br_resolve;
  localparam int XLEN = 64;

  typedef struct {
    logic            nv;
    logic [XLEN-1:0] nd;
    logic            lv;
    logic [XLEN-1:0] ld;
    logic            cv;
    logic [XLEN-1:0] cd;
    logic [7:0]      cx;
    string           tag;
  } exp_t;

  logic clk;
  logic rst_n;

  logic [1:0]      op_kind;
  logic [63:0]     cur_addr;
  logic [23:0]     imm_long;
  logic [13:0]     imm_short;
  logic [4:0]      ctl_mode;
  logic [1:0]      bit_sel;
  logic            abs_tgt;
  logic            link_en;
  logic [3:0]      cr_field;
  logic [63:0]     spr_in;
  logic [7:0]      ctx_in;
  logic            nia_vld;
  logic [63:0]     nia_data;
  logic            lnk_vld;
  logic [63:0]     lnk_data;
  logic            ctr_vld;
  logic [63:0]     ctr_data;
  logic [7:0]      ctx_out;

  int   n_chk;
  int   n_bad;
  bit   done;
  exp_t sb[$];

  br_resolve i_br_resolve (
    .op_kind, .cur_addr, .imm_long, .imm_short, .ctl_mode, .bit_sel,
    .abs_tgt, .link_en, .cr_field, .spr_in, .ctx_in,
    .nia_vld, .nia_data, .lnk_vld, .lnk_data, .ctr_vld, .ctr_data, .ctx_out
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic exp_t model(string tag);
    exp_t e;
    longint li_off;
    longint bd_off;
    logic   cbit, cond, cntok;
    li_off = longint'($signed(imm_long)) * 4;
    bd_off = longint'($signed(imm_short)) * 4;
    cbit   = cr_field[3 - bit_sel];
    cond   = ctl_mode[4] || (cbit == ctl_mode[3]);
    cntok  = ctl_mode[2] || ((spr_in != 0) != ctl_mode[1]);
    e.tag  = tag;
    e.lv   = link_en;
    e.ld   = cur_addr + 64'd4;
    e.cd   = spr_in - 64'd1;
    e.cx   = ctx_in;
    case (op_kind)
      2'd0: begin
        e.nv = 1'b1;
        e.nd = abs_tgt ? 64'(li_off) : cur_addr + 64'(li_off);
        e.cv = 1'b0;
      end
      2'd1: begin
        e.nv = cond && cntok;
        e.nd = abs_tgt ? 64'(bd_off) : cur_addr + 64'(bd_off);
        e.cv = !ctl_mode[2];
      end
      default: begin
        e.nv = cond && cntok;
        e.nd = spr_in;
        e.cv = !ctl_mode[2];
      end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [1:0] op, input logic [63:0] ca,
                       input logic [23:0] li, input logic [13:0] bd,
                       input logic [4:0] ctl, input logic [1:0] sel,
                       input logic aa, input logic lk, input logic [3:0] crf,
                       input logic [63:0] spr, input logic [7:0] cx,
                       input string tag);
    @(posedge clk);
    op_kind = op; cur_addr = ca; imm_long = li; imm_short = bd;
    ctl_mode = ctl; bit_sel = sel; abs_tgt = aa; link_en = lk;
    cr_field = crf; spr_in = spr; ctx_in = cx;
    sb.push_back(model(tag));
  endtask

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compare outputs half a cycle after each drive
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, "nia_vld", 64'(nia_vld), 64'(e.nv));
      if (e.nv) cmp(e.tag, "nia_data", nia_data, e.nd);
      cmp(e.tag, "lnk_vld", 64'(lnk_vld), 64'(e.lv));
      if (e.lv) cmp(e.tag, "lnk_data", lnk_data, e.ld);
      cmp(e.tag, "ctr_vld", 64'(ctr_vld), 64'(e.cv));
      if (e.cv) cmp(e.tag, "ctr_data", ctr_data, e.cd);
      cmp("R11", "ctx_out", 64'(ctx_out), 64'(e.cx));
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    op_kind = '0; cur_addr = '0; imm_long = '0; imm_short = '0;
    ctl_mode = '0; bit_sel = '0; abs_tgt = 1'b0; link_en = 1'b0;
    cr_field = '0; spr_in = '0; ctx_in = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset-state vector: all-zero inputs are an unconditional jump to cur_addr
    drive(2'd0, 64'd0, 24'd0, 14'd0, 5'd0, 2'd0, 1'b0, 1'b0, 4'd0, 64'd0, 8'h00, "R1");
    // R2 relative negative, absolute most-negative, relative wrap with link (R10)
    drive(2'd0, 64'h1000, 24'hFFFFFF, 14'd0, 5'd0, 2'd0, 1'b0, 1'b0, 4'd0, 64'd5, 8'h11, "R2");
    drive(2'd0, 64'h1234, 24'h800000, 14'd0, 5'd0, 2'd0, 1'b1, 1'b0, 4'd0, 64'd5, 8'h22, "R2");
    drive(2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 24'd8, 14'd0, 5'd0, 2'd0, 1'b0, 1'b1, 4'd0, 64'd0, 8'h33, "R2");
    drive(2'd0, 64'hFFFF_FFFF_FFFF_FFFC, 24'd1, 14'd0, 5'd0, 2'd0, 1'b0, 1'b1, 4'd0, 64'd0, 8'h44, "R10");
    // R3 conditional immediate, always-taken control, relative and absolute
    drive(2'd1, 64'h2000, 24'd0, 14'h3FFE, 5'b10100, 2'd0, 1'b0, 1'b0, 4'd0, 64'd9, 8'h55, "R3");
    drive(2'd1, 64'h2000, 24'd0, 14'h2000, 5'b10100, 2'd0, 1'b1, 1'b1, 4'd0, 64'd9, 8'h66, "R3");
    // R5/R6: walk bit select over one-hot fields, both polarities
    for (int k = 0; k < 4; k++) begin
      drive(2'd1, 64'h3000, 24'd0, 14'd4, 5'b01100, 2'(k), 1'b0, 1'b0,
            4'(4'b1000 >> k), 64'd1, 8'(k), "R5");
      drive(2'd1, 64'h3000, 24'd0, 14'd4, 5'b00100, 2'(k), 1'b0, 1'b0,
            4'(4'b1000 >> k), 64'd1, 8'(k), "R6");
      drive(2'd1, 64'h3000, 24'd0, 14'd4, 5'b00100, 2'(k), 1'b0, 1'b0,
            4'(~(4'b1000 >> k)), 64'd1, 8'(k), "R6");
    end
    // R7/R8: decrement and zero test on the pre-decrement value
    drive(2'd1, 64'h4000, 24'd0, 14'd8, 5'b10000, 2'd0, 1'b0, 1'b0, 4'd0, 64'd1, 8'h70, "R8");
    drive(2'd1, 64'h4000, 24'd0, 14'd8, 5'b10000, 2'd0, 1'b0, 1'b0, 4'd0, 64'd0, 8'h71, "R7");
    drive(2'd1, 64'h4000, 24'd0, 14'd8, 5'b10010, 2'd0, 1'b0, 1'b0, 4'd0, 64'd0, 8'h72, "R8");
    drive(2'd1, 64'h4000, 24'd0, 14'd8, 5'b10010, 2'd0, 1'b0, 1'b0, 4'd0, 64'd7, 8'h73, "R8");
    // R9: both tests must pass
    drive(2'd1, 64'h4000, 24'd0, 14'd8, 5'b01000, 2'd0, 1'b0, 1'b0, 4'b1000, 64'd0, 8'h74, "R9");
    drive(2'd1, 64'h4000, 24'd0, 14'd8, 5'b01000, 2'd0, 1'b0, 1'b0, 4'b1000, 64'd3, 8'h75, "R9");
    // R4: register target, with and without decrement
    drive(2'd2, 64'h5000, 24'd0, 14'd0, 5'b10100, 2'd0, 1'b1, 1'b1, 4'd0, 64'hDEAD_BEEF_0000_0010, 8'h80, "R4");
    drive(2'd2, 64'h5000, 24'd0, 14'd0, 5'b10000, 2'd0, 1'b0, 1'b0, 4'd0, 64'h0000_0000_0000_0100, 8'h81, "R4");
    drive(2'd2, 64'h5000, 24'd0, 14'd0, 5'b00110, 2'd3, 1'b0, 1'b1, 4'b0001, 64'd0, 8'h82, "R4");
    // mixed sweep
    for (int i = 0; i < 300; i++) begin
      drive(2'($urandom_range(0, 2)), {$urandom, $urandom}, 24'($urandom),
            14'($urandom), 5'($urandom), 2'($urandom), 1'($urandom),
            1'($urandom), 4'($urandom),
            (i % 5 == 0) ? 64'(i % 3) : {$urandom, $urandom},
            8'($urandom), "R9");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule